// File: doc/BRIEF.md
# Suspend Modulation Clock Throttler

This block throttles a processor core by driving an active-low suspend request in a repeating pattern. One phase holds the request low, which parks the core. The other phase releases it, which lets the core run. Each phase lasts a programmed number of 32 µs ticks. A free-running prescaler derives those ticks from the block clock. If the run phase is R ticks and the parked phase is P ticks, the core delivers R / (R + P) of its full throughput.

Software sets the block up through a byte-wide address/data write port. The same port reads the registers back one cycle later. The registers hold the run count, the park count, a modulation configuration byte and a power-management byte, plus one reload value for each of the two speedup timers. The first speedup timer is retriggered by interrupt activity and the second by display activity. Each timer counts down in 1 ms steps. While either timer is running, the core runs at full speed. When both have expired, modulation starts again from the run phase.

Top module: `susp_throttle`

## Requirements
- R1: After reset, `susp_n` is 1 and every register reads back as 0x00.
- R2: Register addresses: 0x80 power-management byte, 0x8C interrupt timer reload, 0x8D display timer reload, 0x94 run-phase tick count, 0x95 park-phase tick count, 0x96 modulation configuration. A write lands on the clock edge where `reg_wr` is high. `reg_rdata` shows the register at `reg_addr` one clock edge after the address is presented. Any unmapped address reads as 0x00.
- R3: Modulation is active only while bit 0 of 0x96 and bit 0 of 0x80 are both 1. Otherwise `susp_n` is 1 by the second rising edge after the write that cleared either bit, and the phase counters restart.
- R4: When both counts are non-zero, the waveform has a period of (run + park) × TICK_CYCLES clocks, with `susp_n` low for park × TICK_CYCLES clocks of each period.
- R5: With a park count of 0, `susp_n` is never driven low.
- R6: With a run count of 0 and a non-zero park count, `susp_n` stays low continuously.
- R7: A new count written in the middle of a phase does not shorten or lengthen that phase. It applies from the next phase boundary.
- R8: When bit 3 of 0x80 is 1, an `irq_event` pulse loads the interrupt timer from 0x8C. `susp_n` is then high by the second edge after the pulse and stays high until the timer has counted down that many milliseconds (MS_TICKS ticks each).
- R9: When bit 4 of 0x80 is 1, a `video_event` pulse does the same with the display timer and its reload at 0x8D.
- R10: An event whose timer enable bit (bit 3 for interrupts, bit 4 for display) is 0 has no effect on `susp_n`.
- R11: When the speedup timers expire, modulation restarts with a full run phase. This run phase is counted from the expiry, and the core is parked only after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| irq_event | input | 1 | Interrupt activity pulse |
| video_event | input | 1 | Display activity pulse |
| susp_n | output | 1 | Registered active-low suspend request to the core |

## Verification
The assertions assume that the register port writes only whole bytes and that a write and an event may arrive in the same cycle. They also assume that activity pulses can arrive at any time, including while a timer is already running. They assume nothing about when the free-running tick lands relative to a write. The bench therefore measures duty cycle over whole periods, so that its checks do not depend on the tick alignment. Every activity pulse the bench sends lasts one clock and is driven on a falling edge. Modulation is switched off between configurations of the run/park sweep, so each setting starts from a known phase.

// File: rtl/susp_pkg.sv
package susp_pkg;

  localparam int REG_W = 8;

  localparam logic [7:0] ADDR_PM      = 8'h80;
  localparam logic [7:0] ADDR_IRQ_RLD = 8'h8C;
  localparam logic [7:0] ADDR_VID_RLD = 8'h8D;
  localparam logic [7:0] ADDR_RUN     = 8'h94;
  localparam logic [7:0] ADDR_PARK    = 8'h95;
  localparam logic [7:0] ADDR_CFG     = 8'h96;

  localparam int CFG_MOD_EN_BIT = 0;
  localparam int PM_GLOBAL_BIT  = 0;
  localparam int PM_IRQ_BIT     = 3;
  localparam int PM_VID_BIT     = 4;

  localparam int NUM_TIMERS = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_PARK = 2'd2
  } phase_t;

endpackage

// File: rtl/susp_tick_gen.sv
module susp_tick_gen #(
  parameter int TICK_CYCLES = 8000,
  parameter int MS_TICKS    = 31
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o,
  output logic ms_o
);
  localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int MW = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_CYCLES - 1);
  localparam logic [MW-1:0] MS_LAST   = MW'(MS_TICKS - 1);

  logic [TW-1:0] div_q;
  logic [MW-1:0] ms_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      ms_q   <= '0;
      tick_o <= 1'b0;
      ms_o   <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      ms_o   <= 1'b0;
      if (div_q == TICK_LAST) begin
        div_q  <= '0;
        tick_o <= 1'b1;
        if (ms_q == MS_LAST) begin
          ms_q <= '0;
          ms_o <= 1'b1;
        end else begin
          ms_q <= ms_q + 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  AST_MS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    ms_o |-> tick_o); // R4

endmodule

// File: rtl/susp_regfile.sv
module susp_regfile
  import susp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [REG_W-1:0]  run_cnt_o,
  output logic [REG_W-1:0]  park_cnt_o,
  output logic              mod_en_o,
  output logic [NUM_TIMERS-1:0]            tmr_en_o,
  output logic [NUM_TIMERS-1:0][REG_W-1:0] tmr_rld_o
);
  logic [REG_W-1:0] pm_q, irq_rld_q, vid_rld_q, run_q, park_q, cfg_q;
  logic [7:0]       addr8;

  assign addr8 = 8'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_q      <= '0;
      irq_rld_q <= '0;
      vid_rld_q <= '0;
      run_q     <= '0;
      park_q    <= '0;
      cfg_q     <= '0;
    end else if (wr_en) begin
      case (addr8)
        ADDR_PM:      pm_q      <= wdata;
        ADDR_IRQ_RLD: irq_rld_q <= wdata;
        ADDR_VID_RLD: vid_rld_q <= wdata;
        ADDR_RUN:     run_q     <= wdata;
        ADDR_PARK:    park_q    <= wdata;
        ADDR_CFG:     cfg_q     <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr8)
        ADDR_PM:      rdata <= pm_q;
        ADDR_IRQ_RLD: rdata <= irq_rld_q;
        ADDR_VID_RLD: rdata <= vid_rld_q;
        ADDR_RUN:     rdata <= run_q;
        ADDR_PARK:    rdata <= park_q;
        ADDR_CFG:     rdata <= cfg_q;
        default:      rdata <= '0;
      endcase
    end
  end

  assign run_cnt_o    = run_q;
  assign park_cnt_o   = park_q;
  assign mod_en_o     = cfg_q[CFG_MOD_EN_BIT] & pm_q[PM_GLOBAL_BIT];
  assign tmr_en_o[0]  = pm_q[PM_IRQ_BIT];
  assign tmr_en_o[1]  = pm_q[PM_VID_BIT];
  assign tmr_rld_o[0] = irq_rld_q;
  assign tmr_rld_o[1] = vid_rld_q;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr8 == ADDR_PARK) |=> (park_cnt_o == $past(wdata))); // R2

endmodule

// File: rtl/susp_speedup_timer.sv
module susp_speedup_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable_i,
  input  logic         event_i,
  input  logic         ms_i,
  input  logic [W-1:0] reload_i,
  output logic         busy_o
);
  logic [W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (!enable_i) begin
      count_q <= '0;
    end else if (event_i) begin
      count_q <= reload_i;
    end else if (ms_i && count_q != '0) begin
      count_q <= count_q - 1'b1;
    end
  end

  assign busy_o = (count_q != '0);

  AST_TIMER_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (enable_i && event_i) |=> (count_q == $past(reload_i))); // R8

  AST_TIMER_GATED: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> !busy_o); // R10

endmodule

// File: rtl/susp_phase_ctrl.sv
module susp_phase_ctrl
  import susp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mod_en_i,
  input  logic             hold_i,
  input  logic             tick_i,
  input  logic [REG_W-1:0] run_cnt_i,
  input  logic [REG_W-1:0] park_cnt_i,
  output logic             susp_n_o
);
  phase_t           phase_q;
  logic [REG_W-1:0] cnt_q;
  logic [REG_W-1:0] run_len_q, park_len_q;
  logic [REG_W:0]   cnt_inc;
  logic             run_done, park_done;

  assign cnt_inc   = {1'b0, cnt_q} + 1'b1;
  assign run_done  = (cnt_inc >= {1'b0, run_len_q});
  assign park_done = (cnt_inc >= {1'b0, park_len_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      cnt_q      <= '0;
      run_len_q  <= '0;
      park_len_q <= '0;
      susp_n_o   <= 1'b1;
    end else if (!mod_en_i || hold_i) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      susp_n_o <= 1'b1;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          run_len_q  <= run_cnt_i;
          park_len_q <= park_cnt_i;
          cnt_q      <= '0;
          if (run_cnt_i == '0 && park_cnt_i != '0) begin
            phase_q  <= PH_PARK;
            susp_n_o <= 1'b0;
          end else begin
            phase_q  <= PH_RUN;
            susp_n_o <= 1'b1;
          end
        end
        PH_RUN: begin
          if (tick_i) begin
            if (run_done) begin
              run_len_q  <= run_cnt_i;
              park_len_q <= park_cnt_i;
              cnt_q      <= '0;
              if (park_cnt_i != '0) begin
                phase_q  <= PH_PARK;
                susp_n_o <= 1'b0;
              end
            end else begin
              cnt_q <= cnt_inc[REG_W-1:0];
            end
          end
        end
        PH_PARK: begin
          if (tick_i) begin
            if (park_done) begin
              run_len_q  <= run_cnt_i;
              park_len_q <= park_cnt_i;
              cnt_q      <= '0;
              if (run_cnt_i != '0 || park_cnt_i == '0) begin
                phase_q  <= PH_RUN;
                susp_n_o <= 1'b1;
              end
            end else begin
              cnt_q <= cnt_inc[REG_W-1:0];
            end
          end
        end
        default: begin
          phase_q  <= PH_IDLE;
          susp_n_o <= 1'b1;
        end
      endcase
    end
  end

  AST_DISABLED_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !mod_en_i |=> susp_n_o); // R3

  AST_SPEEDUP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> susp_n_o); // R8

  AST_PARK_NEEDS_COUNT: assert property (@(posedge clk) disable iff (rst)
    !susp_n_o |-> (park_len_q != '0)); // R5

  AST_PHASE_STABLE_LEN: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_PARK && !tick_i && $past(phase_q) == PH_PARK && mod_en_i && !hold_i)
      |=> $stable(park_len_q)); // R7

endmodule

// File: rtl/susp_throttle.sv
module susp_throttle
  import susp_pkg::*;
#(
  parameter int TICK_CYCLES = 8000,
  parameter int MS_TICKS    = 31,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              irq_event,
  input  logic              video_event,
  output logic              susp_n
);
  logic                            tick, ms;
  logic [REG_W-1:0]                run_cnt, park_cnt;
  logic                            mod_en;
  logic [NUM_TIMERS-1:0]           tmr_en, tmr_evt, tmr_busy;
  logic [NUM_TIMERS-1:0][REG_W-1:0] tmr_rld;
  logic                            hold;

  susp_tick_gen #(
    .TICK_CYCLES(TICK_CYCLES),
    .MS_TICKS   (MS_TICKS)
  ) u_tick (
    .clk   (clk),
    .rst   (rst),
    .tick_o(tick),
    .ms_o  (ms)
  );

  susp_regfile #(
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .run_cnt_o (run_cnt),
    .park_cnt_o(park_cnt),
    .mod_en_o  (mod_en),
    .tmr_en_o  (tmr_en),
    .tmr_rld_o (tmr_rld)
  );

  assign tmr_evt[0] = irq_event;
  assign tmr_evt[1] = video_event;

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_timer
    susp_speedup_timer #(
      .W(REG_W)
    ) u_timer (
      .clk     (clk),
      .rst     (rst),
      .enable_i(tmr_en[g]),
      .event_i (tmr_evt[g]),
      .ms_i    (ms),
      .reload_i(tmr_rld[g]),
      .busy_o  (tmr_busy[g])
    );
  end

  assign hold = |tmr_busy;

  susp_phase_ctrl u_phase (
    .clk       (clk),
    .rst       (rst),
    .mod_en_i  (mod_en),
    .hold_i    (hold),
    .tick_i    (tick),
    .run_cnt_i (run_cnt),
    .park_cnt_i(park_cnt),
    .susp_n_o  (susp_n)
  );

endmodule

// File: tb/susp_throttle_tb.sv
module susp_throttle_tb;
  localparam int TC = 4;
  localparam int MT = 2;
  localparam int MS_CYC = TC * MT;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_event = 1'b0;
  logic       video_event = 1'b0;
  logic       susp_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  susp_throttle #(.TICK_CYCLES(TC), .MS_TICKS(MT), .ADDR_W(8)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_event(irq_event), .video_event(video_event), .susp_n(susp_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic count_low(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!susp_n) lows++;
    end
  endtask

  task automatic pulse(input bit vid);
    @(negedge clk);
    if (vid) video_event = 1'b1; else irq_event = 1'b1;
    @(negedge clk);
    video_event = 1'b0; irq_event = 1'b0;
  endtask

  // length of the current run of samples equal to lvl, bounded
  task automatic run_len(input logic lvl, output int len);
    len = 0;
    while (susp_n == lvl && len < 400) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int lows, len;
    logic [7:0] addrs [6];
    addrs = '{8'h80, 8'h8C, 8'h8D, 8'h94, 8'h95, 8'h96};

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(susp_n == 1'b1, "R1 reset susp_n", int'(susp_n), 1);
    foreach (addrs[i]) begin
      rd(addrs[i], d);
      check(d == 8'h00, "R1 reset register value", int'(d), 0);
    end

    // R2 write/read-back, plus unmapped address
    foreach (addrs[i]) wr(addrs[i], 8'hA0 + 8'(i) * 8'h03);
    foreach (addrs[i]) begin
      rd(addrs[i], d);
      check(d == 8'hA0 + 8'(i) * 8'h03, "R2 readback", int'(d), int'(8'hA0 + 8'(i) * 8'h03));
    end
    wr(8'h97, 8'h55);
    rd(8'h97, d);
    check(d == 8'h00, "R2 unmapped reads zero", int'(d), 0);
    wr(8'h96, 8'h00);
    wr(8'h80, 8'h00);

    // R3 configuration enable alone is not enough without global bit
    wr(8'h94, 8'd1); wr(8'h95, 8'd3); wr(8'h96, 8'h01);
    count_low(60, lows);
    check(lows == 0, "R3 global bit clear keeps core running", lows, 0);
    wr(8'h80, 8'h01);
    wr(8'h96, 8'h00);

    // R4/R5/R6 sweep over run and park counts
    for (int run = 0; run <= 4; run++) begin
      for (int park = 0; park <= 4; park++) begin
        int win, expl;
        wr(8'h94, 8'(run));
        wr(8'h95, 8'(park));
        wr(8'h96, 8'h01);
        repeat (60) @(negedge clk);
        win  = (run + park > 0) ? 3 * (run + park) * TC : 40;
        expl = (run + park > 0) ? 3 * park * TC : 0;
        count_low(win, lows);
        if (park == 0)
          check(lows == expl, "R5 zero park count never suspends", lows, expl);
        else if (run == 0)
          check(lows == expl, "R6 zero run count suspends continuously", lows, expl);
        else
          check(lows == expl, "R4 duty over whole periods", lows, expl);
        wr(8'h96, 8'h00);
        @(negedge clk);
        check(susp_n == 1'b1, "R3 disable releases suspend", int'(susp_n), 1);
      end
    end

    // R7 mid-phase write takes effect at next boundary
    wr(8'h94, 8'd4); wr(8'h95, 8'd4); wr(8'h96, 8'h01);
    repeat (40) @(negedge clk);
    len = 0;
    while (susp_n == 1'b0 && len < 100) begin @(negedge clk); len++; end
    len = 0;
    while (susp_n == 1'b1 && len < 100) begin @(negedge clk); len++; end
    // first low sample of a park phase is current; rewrite park count now
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h95; reg_wdata = 8'd1;
    @(negedge clk);
    reg_wr = 1'b0;
    run_len(1'b0, len);
    check(len == 4 * TC - 2, "R7 current park phase keeps old length", len, 4 * TC - 2);
    run_len(1'b1, len);
    run_len(1'b0, len);
    check(len == 1 * TC, "R7 next park phase uses new length", len, TC);
    wr(8'h96, 8'h00);

    // R10/R8/R9 with continuous suspend (run 0, park 1)
    wr(8'h94, 8'd0); wr(8'h95, 8'd1);
    wr(8'h8C, 8'd3); wr(8'h8D, 8'd2);
    wr(8'h80, 8'h01); wr(8'h96, 8'h01);
    repeat (20) @(negedge clk);
    pulse(1'b0);
    pulse(1'b1);
    count_low(40, lows);
    check(lows == 40, "R10 events ignored with enables clear", lows, 40);
    wr(8'h80, 8'h09);
    repeat (5) @(negedge clk);
    pulse(1'b1);
    count_low(40, lows);
    check(lows == 40, "R10 display event ignored with only interrupt enable", lows, 40);

    pulse(1'b0);
    @(negedge clk);
    check(susp_n == 1'b1, "R8 interrupt speedup releases", int'(susp_n), 1);
    count_low(2 * MS_CYC - 2, lows);
    check(lows == 0, "R8 held for reload milliseconds", lows, 0);
    count_low(3 * MS_CYC + 8 * TC, lows);
    check(lows > 0, "R8 suspend returns after expiry", lows, 1);

    wr(8'h80, 8'h11);
    repeat (5) @(negedge clk);
    pulse(1'b1);
    @(negedge clk);
    check(susp_n == 1'b1, "R9 display speedup releases", int'(susp_n), 1);
    count_low(1 * MS_CYC - 2, lows);
    check(lows == 0, "R9 held for reload milliseconds", lows, 0);
    count_low(2 * MS_CYC + 8 * TC, lows);
    check(lows > 0, "R9 suspend returns after expiry", lows, 1);

    // R11 restart begins with a run phase (run 3, park 5, reload 2 ms)
    wr(8'h96, 8'h00);
    wr(8'h94, 8'd3); wr(8'h95, 8'd5); wr(8'h8C, 8'd2);
    wr(8'h80, 8'h09); wr(8'h96, 8'h01);
    repeat (20) @(negedge clk);
    len = 0;
    while (susp_n == 1'b1 && len < 100) begin @(negedge clk); len++; end
    @(negedge clk);
    irq_event = 1'b1;
    @(negedge clk);
    irq_event = 1'b0;
    @(negedge clk);
    run_len(1'b1, len);
    len = len + 1;
    check(len >= 18 && len <= 28, "R11 run phase after speedup expiry", len, 18);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule